// File: doc/BRIEF.md
# Alarm Interrupt and Divided-Clock Output Pin

This block drives the interrupt side of a real-time clock. An external time comparator sends it two single-cycle alarm-match strobes. The block keeps a sticky status flag for each alarm, and it drives one active-low output pin. That pin carries one of two things:

- an alarm interrupt pulse, either one-shot or repeating;
- a clock divided down from the 32.768 kHz oscillator that also clocks the block.

Software sets the block up through a register-style write strobe. The write carries three things: the alarm-enable bits, the repeat-mode bit and a two-bit pin-function select. A separate single-cycle strobe marks the point where the status register has been read. That point stands for the end of the eighth bit clock of a serial read.

A status flag records every match, whether or not the alarm is enabled. Each interrupt pulse holds the pin low for a fixed 512 oscillator cycles. In one-shot mode, a config write arms each enabled alarm once. In repeat mode, every enabled match gives a new pulse. Selecting a divided clock takes the pin away from the interrupt function completely.

Top module: `rtc_alarm_irq`

## Requirements
- R1: After reset, and whenever the interrupt function is selected with no pulse running, the pin is high. After reset both status flags read 0.
- R2: A match strobe on alarm i sets status bit i in the following cycle, whether or not that alarm is enabled and whatever pin function is selected.
- R3: The read strobe clears both status flags in the following cycle. If a match and the read strobe hit the same flag in one cycle, that flag ends up set.
- R4: With pin select 00, an enabled match drives the pin low for exactly 512 cycles, starting in the cycle after the strobe. A match on a disabled alarm leaves the pin high.
- R5: A match that arrives while a pulse is already running is merged into that pulse. The pulse keeps its original end point.
- R6: With the repeat bit at 0, only the first enabled match after a config write gives a pulse. Later matches set the flag only, until the next config write re-arms the alarm.
- R7: With the repeat bit at 1, every enabled match that arrives while no pulse is running gives a new pulse.
- R8: Pin select 01 puts the 32.768 kHz clock itself on the pin. While any of the selects 01, 10 or 11 is active, matches never reach the pin.
- R9: Pin select 10 gives a 100 Hz square wave. The divider is a fractional accumulator, so every period lasts 327 or 328 cycles, and 32768 cycles after selection hold exactly 100 rising edges.
- R10: Pin select 11 gives a 1 Hz square wave: high for 16384 cycles in each 32768-cycle period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 32.768 kHz oscillator clock |
| rst_i | input | 1 | Synchronous reset, active high |
| cfg_wr_i | input | 1 | Single-cycle strobe that loads the config fields |
| cfg_alarm_en_i | input | 2 | Per-alarm interrupt enable |
| cfg_repeat_i | input | 1 | 1 = repeating pulses, 0 = one-shot |
| cfg_pin_sel_i | input | 2 | 00 interrupt, 01 32.768 kHz, 10 100 Hz, 11 1 Hz |
| match_i | input | 2 | Single-cycle alarm-match strobes, bit i for alarm i |
| status_rd_i | input | 1 | Single-cycle strobe marking a status-register read |
| status_o | output | 2 | Sticky per-alarm match flags |
| irq_pin_n_o | output | 1 | Shared active-low interrupt / divided-clock pin |

## Verification
Two functions can land on the same cycle.

- **Flag set and clear.** The bench drives a match and the read strobe on the same edge while both flags are already set. The flag that was hit must stay set and the other must clear.
- **Pulse start and a new match.** The bench drives a second alarm's match exactly 100 cycles into a running pulse. The status must show both flags, and the pin must return high at the original 513th cycle with no stretch.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;

    localparam int unsigned NUM_ALARMS = 2;
    localparam int unsigned OSC_HZ     = 32768;

    typedef enum logic [1:0] {
        PIN_IRQ  = 2'b00,
        PIN_F32K = 2'b01,
        PIN_F100 = 2'b10,
        PIN_F1   = 2'b11
    } pin_sel_e;

    typedef struct packed {
        logic [NUM_ALARMS-1:0] alarm_en;
        logic                  repeat_mode;
        pin_sel_e              pin_sel;
    } irq_cfg_t;

    function automatic logic sticky_next(logic cur, logic set, logic clr);
        return set | (cur & ~clr);
    endfunction

endpackage

// File: rtl/alarm_flags.sv
module alarm_flags
    import rtc_irq_pkg::*;
#(
    parameter int unsigned NA = NUM_ALARMS
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic [NA-1:0] match_i,
    input  logic          rd_i,
    output logic [NA-1:0] flags_o
);

    for (genvar g = 0; g < NA; g++) begin : g_flag
        always_ff @(posedge clk_i) begin
            if (rst_i) flags_o[g] <= 1'b0;
            else       flags_o[g] <= sticky_next(flags_o[g], match_i[g], rd_i);
        end
    end

    // R2
    flag_set_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        |match_i |=> ((flags_o & $past(match_i)) == $past(match_i)));

    // R3
    flag_clear_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        rd_i |=> ((flags_o & ~$past(match_i)) == '0));

endmodule

// File: rtl/irq_pulser.sv
module irq_pulser
    import rtc_irq_pkg::*;
#(
    parameter int unsigned NA        = NUM_ALARMS,
    parameter int unsigned PULSE_CYC = 512
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          irq_mode_i,
    input  logic          repeat_i,
    input  logic [NA-1:0] alarm_en_i,
    input  logic          cfg_wr_i,
    input  logic [NA-1:0] new_en_i,
    input  logic [NA-1:0] match_i,
    output logic          active_o
);

    localparam int unsigned CNT_W = $clog2(PULSE_CYC + 1);

    logic [NA-1:0]    armed_q;
    logic [NA-1:0]    fire;
    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        fire = match_i & alarm_en_i & (armed_q | {NA{repeat_i}}) & {NA{irq_mode_i}};
    end

    always_ff @(posedge clk_i) begin
        if (rst_i)         armed_q <= '0;
        else if (cfg_wr_i) armed_q <= new_en_i;
        else if (!repeat_i) armed_q <= armed_q & ~fire;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i || !irq_mode_i)   cnt_q <= '0;
        else if (cnt_q != '0)       cnt_q <= cnt_q - 1'b1;
        else if (|fire)             cnt_q <= CNT_W'(PULSE_CYC);
    end

    assign active_o = (cnt_q != '0);

    // R5
    pulse_countdown_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (cnt_q != '0 && irq_mode_i) |=> (cnt_q == $past(cnt_q) - 1'b1));

    // R4
    pulse_start_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (cnt_q == '0 && |fire) |=> (cnt_q == CNT_W'(PULSE_CYC)));

    // R6
    oneshot_disarm_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (irq_mode_i && !repeat_i && !cfg_wr_i && |(match_i & alarm_en_i & armed_q))
        |=> ((armed_q & $past(match_i & alarm_en_i)) == '0));

endmodule

// File: rtl/frac_clk_div.sv
module frac_clk_div
    import rtc_irq_pkg::*;
#(
    parameter int unsigned CLK_HZ = OSC_HZ,
    parameter int unsigned OUT_HZ = 100
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic en_i,
    output logic out_o
);

    localparam int unsigned STEP  = 2 * OUT_HZ;
    localparam int unsigned ACC_W = $clog2(CLK_HZ + STEP + 1);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] sum;

    always_comb sum = acc_q + ACC_W'(STEP);

    always_ff @(posedge clk_i) begin
        if (rst_i || !en_i) begin
            acc_q <= '0;
            out_o <= 1'b0;
        end else if (sum >= ACC_W'(CLK_HZ)) begin
            acc_q <= sum - ACC_W'(CLK_HZ);
            out_o <= ~out_o;
        end else begin
            acc_q <= sum;
        end
    end

    // R9
    div_idle_low_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !en_i |=> (!out_o && acc_q == '0));

    // R10
    div_acc_bound_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        en_i |=> (acc_q < ACC_W'(CLK_HZ)));

endmodule

// File: rtl/rtc_alarm_irq.sv
module rtc_alarm_irq
    import rtc_irq_pkg::*;
#(
    parameter int unsigned PULSE_CYC = 512,
    parameter int unsigned CLK_HZ    = OSC_HZ,
    parameter int unsigned MID_HZ    = 100,
    parameter int unsigned LOW_HZ    = 1
) (
    input  logic                  clk_i,
    input  logic                  rst_i,
    input  logic                  cfg_wr_i,
    input  logic [NUM_ALARMS-1:0] cfg_alarm_en_i,
    input  logic                  cfg_repeat_i,
    input  logic [1:0]            cfg_pin_sel_i,
    input  logic [NUM_ALARMS-1:0] match_i,
    input  logic                  status_rd_i,
    output logic [NUM_ALARMS-1:0] status_o,
    output logic                  irq_pin_n_o
);

    irq_cfg_t cfg_q;
    logic     pulse_active;
    logic     div_mid, div_low;
    logic     irq_mode;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cfg_q <= '{alarm_en: '0, repeat_mode: 1'b0, pin_sel: PIN_IRQ};
        end else if (cfg_wr_i) begin
            cfg_q <= '{alarm_en: cfg_alarm_en_i, repeat_mode: cfg_repeat_i,
                       pin_sel: pin_sel_e'(cfg_pin_sel_i)};
        end
    end

    assign irq_mode = (cfg_q.pin_sel == PIN_IRQ);

    alarm_flags #(.NA(NUM_ALARMS)) u_flags (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .match_i (match_i),
        .rd_i    (status_rd_i),
        .flags_o (status_o)
    );

    irq_pulser #(.NA(NUM_ALARMS), .PULSE_CYC(PULSE_CYC)) u_pulser (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .irq_mode_i (irq_mode),
        .repeat_i   (cfg_q.repeat_mode),
        .alarm_en_i (cfg_q.alarm_en),
        .cfg_wr_i   (cfg_wr_i),
        .new_en_i   (cfg_alarm_en_i),
        .match_i    (match_i),
        .active_o   (pulse_active)
    );

    frac_clk_div #(.CLK_HZ(CLK_HZ), .OUT_HZ(MID_HZ)) u_div_mid (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .en_i  (cfg_q.pin_sel == PIN_F100),
        .out_o (div_mid)
    );

    frac_clk_div #(.CLK_HZ(CLK_HZ), .OUT_HZ(LOW_HZ)) u_div_low (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .en_i  (cfg_q.pin_sel == PIN_F1),
        .out_o (div_low)
    );

    always_comb begin
        unique case (cfg_q.pin_sel)
            PIN_IRQ:  irq_pin_n_o = ~pulse_active;
            PIN_F32K: irq_pin_n_o = clk_i;
            PIN_F100: irq_pin_n_o = div_mid;
            PIN_F1:   irq_pin_n_o = div_low;
            default:  irq_pin_n_o = 1'b1;
        endcase
    end

    // R8
    freq_mode_no_pulse_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !irq_mode |=> !pulse_active);

    // R8
    div_exclusive_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0({div_mid, div_low}));

endmodule

// File: tb/tb_rtc_alarm_irq.sv
module tb_rtc_alarm_irq;
    import rtc_irq_pkg::*;

    logic       clk = 1'b0;
    logic       rst;
    logic       cfg_wr = 1'b0;
    logic [1:0] cfg_en = '0;
    logic       cfg_rep = 1'b0;
    logic [1:0] cfg_sel = '0;
    logic [1:0] match = '0;
    logic       rd = 1'b0;
    logic [1:0] status;
    logic       pin;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc++;

    rtc_alarm_irq dut (
        .clk_i          (clk),
        .rst_i          (rst),
        .cfg_wr_i       (cfg_wr),
        .cfg_alarm_en_i (cfg_en),
        .cfg_repeat_i   (cfg_rep),
        .cfg_pin_sel_i  (cfg_sel),
        .match_i        (match),
        .status_rd_i    (rd),
        .status_o       (status),
        .irq_pin_n_o    (pin)
    );

    typedef struct {
        int         at;
        bit         ck_pin;
        logic       pin;
        bit         ck_st;
        logic [1:0] st;
        string      tag;
    } exp_t;

    exp_t q[$];
    exp_t e;

    task automatic push(int at, bit ck_pin, logic p, bit ck_st, logic [1:0] s, string tag);
        exp_t x;
        x.at = at; x.ck_pin = ck_pin; x.pin = p; x.ck_st = ck_st; x.st = s; x.tag = tag;
        q.push_back(x);
    endtask

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].at <= cyc) begin
            e = q.pop_front();
            if (e.at < cyc) begin
                check(1'b0, e.tag, cyc, e.at);
            end else begin
                if (e.ck_pin) check(pin == e.pin, {e.tag, " pin"}, int'(pin), int'(e.pin));
                if (e.ck_st)  check(status == e.st, {e.tag, " status"}, int'(status), int'(e.st));
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        if (cyc > 190000) begin
            check(1'b0, "watchdog", cyc, 190000);
            finish_run();
        end
    end

    task automatic cfg_write(logic [1:0] en, logic rep, logic [1:0] sel);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_en = en; cfg_rep = rep; cfg_sel = sel;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic drive(logic [1:0] m, logic r);
        @(negedge clk);
        match = m; rd = r;
    endtask

    task automatic idle();
        @(negedge clk);
        match = '0; rd = 1'b0;
    endtask

    task automatic flush();
        while (q.size() > 0) @(negedge clk);
    endtask

    int base;
    int rises, highs, bad, last_rise;
    logic prev;

    initial begin
        rst = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(pin == 1'b1, "R1 pin after reset", int'(pin), 1);
        check(status == 2'b00, "R1 status after reset", int'(status), 0);

        // disabled alarm: flag only (R2, R4)
        cfg_write(2'b01, 1'b0, 2'b00);
        drive(2'b10, 1'b0); base = cyc;
        push(base + 1, 1, 1'b1, 1, 2'b10, "R2 disabled alarm sets flag");
        push(base + 3, 1, 1'b1, 0, 2'b00, "R4 disabled alarm no pulse");
        idle(); flush();
        drive(2'b00, 1'b1); base = cyc;
        push(base + 1, 0, 1'b0, 1, 2'b00, "R3 read clears");
        idle(); flush();

        // enabled one-shot pulse (R4)
        drive(2'b01, 1'b0); base = cyc;
        push(base + 1,   1, 1'b0, 1, 2'b01, "R4 pulse start");
        push(base + 512, 1, 1'b0, 0, 2'b00, "R4 pulse last low");
        push(base + 513, 1, 1'b1, 0, 2'b00, "R4 pulse end");
        idle(); flush();

        // one-shot: no second pulse until rewrite (R6)
        drive(2'b00, 1'b1); idle();
        drive(2'b01, 1'b0); base = cyc;
        push(base + 1,  1, 1'b1, 1, 2'b01, "R6 unarmed match");
        push(base + 10, 1, 1'b1, 0, 2'b00, "R6 unarmed no pulse");
        idle(); flush();
        cfg_write(2'b01, 1'b0, 2'b00);
        drive(2'b01, 1'b0); base = cyc;
        push(base + 1,   1, 1'b0, 0, 2'b00, "R6 rearmed pulse");
        push(base + 513, 1, 1'b1, 0, 2'b00, "R6 rearmed pulse end");
        idle(); flush();

        // repeat mode with merge (R5, R7)
        cfg_write(2'b11, 1'b1, 2'b00);
        drive(2'b00, 1'b1); base = cyc;
        push(base + 1, 0, 1'b0, 1, 2'b00, "R3 clear before repeat");
        idle(); flush();
        drive(2'b01, 1'b0); base = cyc;
        push(base + 1,   1, 1'b0, 1, 2'b01, "R7 repeat pulse");
        push(base + 101, 1, 1'b0, 1, 2'b11, "R5 merged match flag");
        push(base + 512, 1, 1'b0, 0, 2'b00, "R5 merged last low");
        push(base + 513, 1, 1'b1, 0, 2'b00, "R5 merged no stretch");
        idle();
        while (cyc < base + 99) @(negedge clk);
        drive(2'b10, 1'b0);
        idle(); flush();
        drive(2'b10, 1'b0); base = cyc;
        push(base + 1,   1, 1'b0, 0, 2'b00, "R7 second pulse");
        push(base + 513, 1, 1'b1, 0, 2'b00, "R7 second pulse end");
        idle(); flush();

        // set and clear together (R3)
        drive(2'b01, 1'b1); base = cyc;
        push(base + 1,   0, 1'b0, 1, 2'b01, "R3 set wins over read");
        push(base + 513, 1, 1'b1, 0, 2'b00, "R3 pulse end");
        idle(); flush();

        // 32.768 kHz passthrough, matches blocked (R8)
        cfg_write(2'b11, 1'b1, 2'b01);
        @(negedge clk);
        drive(2'b01, 1'b1); base = cyc;
        push(base + 1, 0, 1'b0, 1, 2'b01, "R8 flag in freq mode");
        idle();
        bad = 0;
        for (int i = 0; i < 600; i++) begin
            @(posedge clk); #1;
            if (pin !== 1'b1) bad++;
            @(negedge clk); #1;
            if (pin !== 1'b0) bad++;
        end
        check(bad == 0, "R8 pin follows clock", bad, 0);
        flush();

        // 100 Hz (R9)
        cfg_write(2'b11, 1'b1, 2'b10);
        rises = 0; bad = 0; last_rise = -1; prev = pin;
        check(pin == 1'b0, "R9 starts low", int'(pin), 0);
        for (int i = 1; i < 32768; i++) begin
            @(negedge clk);
            if (pin && !prev) begin
                rises++;
                if (last_rise >= 0 && (i - last_rise < 327 || i - last_rise > 328)) bad++;
                last_rise = i;
            end
            prev = pin;
        end
        check(rises == 100, "R9 rising edges", rises, 100);
        check(bad == 0, "R9 period 327/328", bad, 0);

        // 1 Hz (R10)
        cfg_write(2'b11, 1'b1, 2'b11);
        rises = 0; highs = 0; prev = pin;
        if (pin) highs++;
        for (int i = 1; i < 65536; i++) begin
            @(negedge clk);
            if (pin) highs++;
            if (pin && !prev) rises++;
            prev = pin;
        end
        check(rises == 2, "R10 rising edges", rises, 2);
        check(highs == 32768, "R10 high cycles", highs, 32768);

        // back to interrupt function (R1)
        cfg_write(2'b11, 1'b1, 2'b00);
        check(pin == 1'b1, "R1 idle after freq mode", int'(pin), 1);

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule